// File: doc/BRIEF.md
# Repeated String Copy Sequencer

This block steps a repeated block-copy for a small 16-bit datapath. When started it loads a source index, a destination index and an element count. For each element it issues one memory read at the source index through the data segment. It then issues one memory write at the destination index through the extra segment, carrying the word just read. After each element, both indices move by the element size (1 for bytes, 2 for words). They move up or down according to a direction flag, and the count decreases by one. The sequence stops when the count reaches zero.

The memory side is a single request port. It carries a segment select, a 16-bit offset, a write flag and write data, and each request is held until the memory returns ready. Physical address formation is left to the surrounding logic. When the copy ends, the updated indices and count stay visible on the result outputs, and a one-cycle done pulse is issued.

Top module: `strseq_xfer`

## Requirements
- R1: While reset is held and after it is released, busy, done and mem_req are all 0 until a start is accepted.
- R2: start is accepted only while busy is 0. A start pulse while busy is 1 has no effect on the running copy or on its final results.
- R3: If init_cnt is 0 when start is accepted, no memory request is issued, and done is 1 in the cycle after the accepting edge.
- R4: Each element is a read (mem_we=0, mem_seg=0 meaning data segment, mem_off = source index), followed directly by a write (mem_we=1, mem_seg=1 meaning extra segment, mem_off = destination index).
- R5: The write data of each element equals the mem_rdata returned by that element's accepted read.
- R6: A request is taken only in a cycle where mem_ready is 1. While mem_ready is 0, mem_req, mem_we and mem_off hold their values.
- R7: After each element, both indices change by the step (1 when word_mode=0, 2 when word_mode=1). They increase when dir_dec=0 and decrease when dir_dec=1, wrapping modulo 2^16.
- R8: The count drops by one per completed write, and exactly init_cnt elements are copied.
- R9: done is a one-cycle pulse in the cycle after the final write is accepted, and busy is 0 in the following cycle. While done is 1, fin_src, fin_dst and fin_cnt show the final source index, destination index and a count of 0.
- R10: dir_dec, word_mode and the init values are sampled only when start is accepted. Changing them during the copy has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a copy (taken when not busy) |
| dir_dec | input | 1 | 1 = indices decrement, 0 = increment |
| word_mode | input | 1 | 1 = word elements (step 2), 0 = byte elements (step 1) |
| init_src | input | 16 | Starting source index |
| init_dst | input | 16 | Starting destination index |
| init_cnt | input | 16 | Element count |
| busy | output | 1 | Copy in progress, including the done cycle |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_seg | output | 1 | 0 = data segment, 1 = extra segment |
| mem_off | output | 16 | Offset within the selected segment |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ready on a read |
| mem_ready | input | 1 | Memory accepts the current request |
| fin_src | output | 16 | Current or final source index |
| fin_dst | output | 16 | Current or final destination index |
| fin_cnt | output | 16 | Current or final remaining count |

## Verification
Two functions can fall in the same cycle. The first is the last write being accepted, which steps both indices, drops the count to zero and schedules done. The second is a new start arriving on the input. The bench pulses start with unrelated init values, direction and width in the middle of copies and right up to their end, while mem_ready stalls at random. It then judges the run by the final indices and the element count, which must match values computed from the original start only. A zero count is also started directly, to show that done can follow the start without any memory cycle in between.

// File: rtl/strseq_pkg.sv
package strseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_FIN   = 2'd3
  } strseq_state_e;

  typedef enum logic {
    SEG_DATA  = 1'b0,
    SEG_EXTRA = 1'b1
  } strseq_seg_e;
endpackage

// File: rtl/strseq_index_bank.sv
module strseq_index_bank #(
  parameter int W = 16,
  parameter int N = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [N-1:0][W-1:0] load_val,
  input  logic                step_en,
  input  logic                dir_dec,
  input  logic                wide,
  output logic [N-1:0][W-1:0] idx
);
  function automatic logic [W-1:0] step_index(input logic [W-1:0] v,
                                               input logic dec,
                                               input logic wd);
    logic [W-1:0] amt;
    amt = wd ? W'(2) : W'(1);
    return dec ? v - amt : v + amt;
  endfunction

  for (genvar i = 0; i < N; i++) begin : g_idx
    always_ff @(posedge clk) begin
      if (!rst_n)       idx[i] <= '0;
      else if (load)    idx[i] <= load_val[i];
      else if (step_en) idx[i] <= step_index(idx[i], dir_dec, wide);
    end
  end
endmodule

// File: rtl/strseq_counter.sv
module strseq_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec_en,
  output logic [W-1:0] cnt,
  output logic         last
);
  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (load)   cnt <= load_val;
    else if (dec_en) cnt <= cnt - W'(1);
  end

  assign last = (cnt == W'(1));
endmodule

// File: rtl/strseq_fsm.sv
module strseq_fsm
  import strseq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          zero_init,
  input  logic          mem_ready,
  input  logic          last,
  output strseq_state_e state,
  output logic          start_taken,
  output logic          rd_fire,
  output logic          wr_fire
);
  strseq_state_e nxt;

  assign start_taken = (state == ST_IDLE) && start;
  assign rd_fire     = (state == ST_READ) && mem_ready;
  assign wr_fire     = (state == ST_WRITE) && mem_ready;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:  if (start) nxt = zero_init ? ST_FIN : ST_READ;
      ST_READ:  if (mem_ready) nxt = ST_WRITE;
      ST_WRITE: if (mem_ready) nxt = last ? ST_FIN : ST_READ;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/strseq_xfer.sv
module strseq_xfer
  import strseq_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dir_dec,
  input  logic          word_mode,
  input  logic [AW-1:0] init_src,
  input  logic [AW-1:0] init_dst,
  input  logic [CW-1:0] init_cnt,
  output logic          busy,
  output logic          done,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_seg,
  output logic [AW-1:0] mem_off,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic [AW-1:0] fin_src,
  output logic [AW-1:0] fin_dst,
  output logic [CW-1:0] fin_cnt
);
  localparam int SRC = 0;
  localparam int DST = 1;

  strseq_state_e        state;
  logic                 start_taken, rd_fire, wr_fire, last;
  logic                 dir_q, wide_q;
  logic [DW-1:0]        buf_q;
  logic [1:0][AW-1:0]   init_idx, idx;

  assign init_idx[SRC] = init_src;
  assign init_idx[DST] = init_dst;

  strseq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start),
    .zero_init(init_cnt == '0), .mem_ready(mem_ready), .last(last),
    .state(state), .start_taken(start_taken),
    .rd_fire(rd_fire), .wr_fire(wr_fire)
  );

  strseq_index_bank #(.W(AW), .N(2)) u_idx (
    .clk(clk), .rst_n(rst_n), .load(start_taken), .load_val(init_idx),
    .step_en(wr_fire), .dir_dec(dir_q), .wide(wide_q), .idx(idx)
  );

  strseq_counter #(.W(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(start_taken), .load_val(init_cnt),
    .dec_en(wr_fire), .cnt(fin_cnt), .last(last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= 1'b0;
      wide_q <= 1'b0;
      buf_q  <= '0;
    end else begin
      if (start_taken) begin
        dir_q  <= dir_dec;
        wide_q <= word_mode;
      end
      if (rd_fire) buf_q <= mem_rdata;
    end
  end

  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_FIN);
  assign mem_req   = (state == ST_READ) || (state == ST_WRITE);
  assign mem_we    = (state == ST_WRITE);
  assign mem_seg   = (state == ST_WRITE) ? SEG_EXTRA : SEG_DATA;
  assign mem_off   = (state == ST_WRITE) ? idx[DST] : idx[SRC];
  assign mem_wdata = buf_q;
  assign fin_src   = idx[SRC];
  assign fin_dst   = idx[DST];
endmodule

// File: rtl/strseq_xfer_chk.sv
module strseq_xfer_chk #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_seg,
  input logic [AW-1:0] mem_off,
  input logic [DW-1:0] mem_wdata,
  input logic [DW-1:0] mem_rdata,
  input logic          mem_ready,
  input logic [CW-1:0] init_cnt,
  input logic [CW-1:0] fin_cnt,
  input logic          start_taken,
  input logic          rd_fire,
  input logic          wr_fire
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !done);

  assert_zero_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_taken && (init_cnt == '0) |=> done && !mem_req);

  assert_read_seg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> mem_seg == 1'b0);

  assert_write_seg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_seg == 1'b1);

  assert_read_then_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> mem_req && mem_we);

  assert_wdata_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> mem_wdata == $past(mem_rdata));

  assert_hold_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_off) && $stable(mem_we));

  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> fin_cnt == $past(fin_cnt) - CW'(1));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  assert_done_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> fin_cnt == '0);
endmodule

bind strseq_xfer strseq_xfer_chk #(.AW(AW), .CW(CW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mem_req(mem_req),
  .mem_we(mem_we), .mem_seg(mem_seg), .mem_off(mem_off),
  .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
  .init_cnt(init_cnt), .fin_cnt(fin_cnt), .start_taken(start_taken),
  .rd_fire(rd_fire), .wr_fire(wr_fire)
);

// File: tb/tb_strseq_xfer.sv
module tb_strseq_xfer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, dir_dec = 1'b0, word_mode = 1'b0;
  logic [15:0] init_src = '0, init_dst = '0, init_cnt = '0;
  logic        busy, done, mem_req, mem_we, mem_seg, mem_ready = 1'b0;
  logic [15:0] mem_off, mem_wdata, mem_rdata, fin_src, fin_dst, fin_cnt;

  int checks = 0, fails = 0;
  int rd_k = 0, wr_k = 0;
  bit rand_ready = 1'b0;
  logic [15:0] cur_src = '0, cur_dst = '0;
  bit cur_dec = 1'b0, cur_wide = 1'b0;
  bit pend = 1'b0;
  logic [15:0] pend_off = '0;
  logic pend_we = 1'b0;

  always #5 clk = ~clk;

  strseq_xfer dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_dec(dir_dec),
    .word_mode(word_mode), .init_src(init_src), .init_dst(init_dst),
    .init_cnt(init_cnt), .busy(busy), .done(done), .mem_req(mem_req),
    .mem_we(mem_we), .mem_seg(mem_seg), .mem_off(mem_off),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .fin_src(fin_src), .fin_dst(fin_dst), .fin_cnt(fin_cnt)
  );

  function automatic logic [15:0] pattern(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h3C5A;
  endfunction

  function automatic logic [15:0] exp_off(input logic [15:0] base, input int k,
                                          input bit dec, input bit wide);
    logic [15:0] d;
    d = 16'(k * (wide ? 2 : 1));
    return dec ? base - d : base + d;
  endfunction

  assign mem_rdata = pattern(mem_off);

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always begin
    @(negedge clk);
    mem_ready = !rst_n ? 1'b0 : (rand_ready ? (($urandom % 4) != 0) : 1'b1);
    #1;
    if (rst_n) begin
      if (pend && mem_req) begin
        check(mem_off == pend_off, "R6 offset held", mem_off, pend_off);
        check(mem_we == pend_we, "R6 direction held", mem_we, pend_we);
      end
      if (mem_req && mem_ready) begin
        if (!mem_we) begin
          check(rd_k == wr_k, "R4 read follows write", rd_k, wr_k);
          check(mem_seg == 1'b0, "R4 read segment", mem_seg, 0);
          check(mem_off == exp_off(cur_src, rd_k, cur_dec, cur_wide), "R7 read offset",
                mem_off, exp_off(cur_src, rd_k, cur_dec, cur_wide));
          rd_k++;
        end else begin
          check(rd_k == wr_k + 1, "R4 write follows read", wr_k, rd_k - 1);
          check(mem_seg == 1'b1, "R4 write segment", mem_seg, 1);
          check(mem_off == exp_off(cur_dst, wr_k, cur_dec, cur_wide), "R7 write offset",
                mem_off, exp_off(cur_dst, wr_k, cur_dec, cur_wide));
          check(mem_wdata == pattern(exp_off(cur_src, wr_k, cur_dec, cur_wide)),
                "R5 write data", mem_wdata,
                pattern(exp_off(cur_src, wr_k, cur_dec, cur_wide)));
          wr_k++;
        end
      end
      pend     = mem_req && !mem_ready;
      pend_off = mem_off;
      pend_we  = mem_we;
    end
  end

  task automatic run_op(input logic [15:0] src, input logic [15:0] dst,
                        input logic [15:0] cnt, input bit dec, input bit wide,
                        input bit poke);
    int n;
    @(negedge clk);
    cur_src = src; cur_dst = dst; cur_dec = dec; cur_wide = wide;
    rd_k = 0; wr_k = 0;
    init_src = src; init_dst = dst; init_cnt = cnt;
    dir_dec = dec; word_mode = wide; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R10: inputs scrambled once the copy has begun
    dir_dec = ~dec; word_mode = ~wide;
    init_src = 16'($urandom); init_dst = 16'($urandom); init_cnt = 16'($urandom);
    if (cnt == 0) begin
      check(done == 1'b1, "R3 done right after start", done, 1);
    end else begin
      n = 0;
      while (!done) begin
        @(negedge clk);
        n++;
        // R2: start while busy must be ignored
        start = poke && (n == 3 || n == 4);
      end
      start = 1'b0;
    end
    #2;
    check(rd_k == int'(cnt), "R8 element reads", rd_k, cnt);
    check(wr_k == int'(cnt), "R8 element writes", wr_k, cnt);
    check(fin_src == exp_off(src, cnt, dec, wide), "R7 final source",
          fin_src, exp_off(src, cnt, dec, wide));
    check(fin_dst == exp_off(dst, cnt, dec, wide), "R7 final destination",
          fin_dst, exp_off(dst, cnt, dec, wide));
    check(fin_cnt == 16'd0, "R9 final count", fin_cnt, 0);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R9 done one cycle", {done, busy}, 0);
    check(rd_k == int'(cnt), "R2 no extra copy", rd_k, cnt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && mem_req == 1'b0, "R1 in reset",
          {busy, done, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && mem_req == 1'b0, "R1 after reset",
          {busy, done, mem_req}, 0);
    // directed corners
    run_op(16'h1000, 16'h2000, 16'd0, 1'b0, 1'b1, 1'b0);       // R3
    run_op(16'h0100, 16'h0200, 16'd1, 1'b0, 1'b0, 1'b0);
    run_op(16'h0001, 16'h0000, 16'd3, 1'b1, 1'b1, 1'b0);       // R7 wrap down
    run_op(16'hFFFE, 16'hFFFF, 16'd4, 1'b0, 1'b0, 1'b1);       // R7 wrap up, R2
    rand_ready = 1'b1;
    run_op(16'h4000, 16'h5000, 16'd6, 1'b1, 1'b0, 1'b1);       // R6 stalls
    run_op(16'h0000, 16'h0000, 16'd0, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 40; i++) begin
      rand_ready = ($urandom % 3) != 0;
      run_op(16'($urandom), 16'($urandom), 16'(1 + $urandom % 20),
             1'($urandom), 1'($urandom), 1'($urandom % 2));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule